// File: doc/BRIEF.md
# Host Port Burst Request Generator

This block sits behind the data register of a host interface port and turns host accesses into memory transfer requests. It holds two small FIFOs of 32-bit words. One is a read prefetch FIFO that memory fills. The other is a write FIFO that the host fills. For every request it decides when to send it and how many words it covers. The size depends on the access mode (single access or auto-increment), on how full the read FIFO is, and on whether a read request is still in flight.

In single-access mode, every host read or write becomes a one-word request at the fixed host address. In auto-increment mode, the host address advances by 4 bytes per word, and the block moves data in bursts. A read that finds the prefetch FIFO empty fetches eight words. Reads that leave the FIFO at most half full, with nothing outstanding, top it up with four more contiguous words. Every fourth auto-increment write sends a four-word write request. On leaving auto-increment mode, the block discards prefetched data and sends any write words not yet covered by a request before the next single access.

The memory side is one request channel (valid/ready) that carries direction, byte address and word count. Write data follows an accepted write request, one word per cycle. Read data returns in order, one word per cycle.

Top module: `hp_burst_gen`

## Requirements
- R1: After reset no request is presented (`mreq_valid`=0), no write data is streamed (`mwd_valid`=0) and `host_ready` is 0.
- R2: In single-access mode (`host_autoinc`=0) a host read with an empty read FIFO and no read outstanding issues one read request with `mreq_len`=1 at the host address. The host address does not change, so a second single read requests the same address again.
- R3: In auto-increment mode a host read that finds the read FIFO empty with no read outstanding issues a read request with `mreq_len`=8 at the host address. The returned words reach `host_rdata` in address order.
- R4: In auto-increment mode a host read completed while the read FIFO holds between 1 and 4 words and no read is outstanding issues a read request with `mreq_len`=4. Its address is the byte after the last word already requested, so successive read requests are contiguous.
- R5: No read request is issued while read words are still outstanding, or while an auto-increment read completes with more than 4 words in the read FIFO.
- R6: In single-access mode a host write issues a write request (`mreq_write`=1) with `mreq_len`=1 at the host address, carrying the written word.
- R7: In auto-increment mode a write request with `mreq_len`=4 is issued when the fourth word since the last write request has been written, and not before. It starts at the address of the first of those words.
- R8: In auto-increment mode the host address advances by 4 bytes for each word the host reads or writes.
- R9: `host_ready` stays 0 for a read while the read FIFO is empty, and for an auto-increment write while the write FIFO holds 8 words.
- R10: When `host_autoinc` falls, the read FIFO is emptied, so the next single read issues a fresh one-word request. Write words not yet covered by a request are issued as one request of exactly that count, before any single-access write request.
- R11: A presented request keeps `mreq_valid`, `mreq_write`, `mreq_addr` and `mreq_len` unchanged until `mreq_ready` accepts it.
- R12: After a write request of N words is accepted, `mwd_valid` is high in each of the next N cycles with the buffered words in write order. It is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_autoinc | input | 1 | 1 = auto-increment mode, 0 = single-access mode |
| haddr_ld | input | 1 | Load the host address from `haddr_in`; empties the read FIFO |
| haddr_in | input | AW (16) | Byte address to load |
| host_rd | input | 1 | Host read of the data register, held until `host_ready` |
| host_wr | input | 1 | Host write of the data register, held until `host_ready` |
| host_wdata | input | DW (32) | Host write word |
| host_rdata | output | DW (32) | Word at the head of the read FIFO |
| host_ready | output | 1 | Current host access completes at this clock edge |
| mreq_valid | output | 1 | Memory request presented |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_write | output | 1 | 1 = write request, 0 = read request |
| mreq_addr | output | AW (16) | Request start byte address |
| mreq_len | output | 4 | Request length in words (1 to 8) |
| mwd_valid | output | 1 | Write data word valid |
| mwd_data | output | DW (32) | Write data word |
| mrd_valid | input | 1 | Read data word returned |
| mrd_data | input | DW (32) | Returned read word |

## Verification
The block's internal state shows up at the ports through the request sizes and addresses. A wrong fill count or outstanding counter produces a request of the wrong length, or a missing or extra request. This is visible within a cycle or two of the host access that should (or should not) have triggered it. A wrong prefetch or write address breaks the contiguity of successive requests, and the data the host reads no longer matches the addresses it walked. A lost or duplicated FIFO word shifts every following `host_rdata` or `mwd_data` word. A broken stream counter leaves a gap or an extra beat right after a write request is accepted.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [1:0] {
        RSZ_NONE = 2'd0,
        RSZ_ONE  = 2'd1,
        RSZ_QUAD = 2'd2,
        RSZ_OCT  = 2'd3
    } rsz_e;

    // words covered by a read request of the given kind for a FIFO of depth d
    function automatic int unsigned rsz_words(rsz_e s, int unsigned d);
        case (s)
            RSZ_ONE:  return 1;
            RSZ_QUAD: return d / 2;
            RSZ_OCT:  return d;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/hp_fifo.sv
module hp_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST_C  = PW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp = (st_q.wp == LAST_C) ? '0 : st_q.wp + 1'b1;
            end
            if (pop) begin
                st_d.rp = (st_q.rp == LAST_C) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> (st_q.cnt != DEPTH_C)); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (st_q.cnt != '0)); // R9

endmodule

// File: rtl/hp_rd_sizer.sv
module hp_rd_sizer #(
    parameter int DEPTH = 8
) (
    input  logic                        rd,
    input  logic                        autoinc,
    input  logic [$clog2(DEPTH+1)-1:0]  rcount,
    input  logic                        idle,
    input  logic                        slot_free,
    input  logic                        hold,
    output hp_pkg::rsz_e                size
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    always_comb begin
        size = hp_pkg::RSZ_NONE;
        if (rd && idle && slot_free && !hold) begin
            if (rcount == '0)
                size = autoinc ? hp_pkg::RSZ_OCT : hp_pkg::RSZ_ONE;
            else if (autoinc && rcount <= HALF_C)
                size = hp_pkg::RSZ_QUAD;
        end
    end

endmodule

// File: rtl/hp_burst_gen.sv
module hp_burst_gen #(
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_autoinc,
    input  logic                         haddr_ld,
    input  logic [AW-1:0]                haddr_in,
    input  logic                         host_rd,
    input  logic                         host_wr,
    input  logic [DW-1:0]                host_wdata,
    output logic [DW-1:0]                host_rdata,
    output logic                         host_ready,
    output logic                         mreq_valid,
    input  logic                         mreq_ready,
    output logic                         mreq_write,
    output logic [AW-1:0]                mreq_addr,
    output logic [$clog2(DEPTH+1)-1:0]   mreq_len,
    output logic                         mwd_valid,
    output logic [DW-1:0]                mwd_data,
    input  logic                         mrd_valid,
    input  logic [DW-1:0]                mrd_data
);
    import hp_pkg::*;

    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

    typedef struct packed {
        logic          auto_m;
        logic [AW-1:0] haddr;
        logic [AW-1:0] faddr;
        logic [AW-1:0] waddr;
        logic [CW-1:0] uncov;
        logic [CW-1:0] rout;
        logic [CW-1:0] rdrop;
        logic [CW-1:0] wstr;
        logic          mv;
        logic          mw;
        logic [AW-1:0] ma;
        logic [CW-1:0] ml;
    } gen_st_t;

    gen_st_t st_q, st_d;

    logic [CW-1:0] rf_count, wf_count;
    logic [DW-1:0] rf_dout, wf_dout;
    logic          flush, fire, slot_free, wgen, rd_ok, wr_ok, rf_push, wpop;
    logic [CW-1:0] wlen, rlen, uncov_rem;
    rsz_e          rsz;

    assign flush     = (st_q.auto_m && !host_autoinc) || haddr_ld;
    assign fire      = st_q.mv && mreq_ready;
    assign slot_free = !st_q.mv;
    assign wgen      = slot_free && (host_autoinc ? (st_q.uncov >= HALF_C)
                                                  : (st_q.uncov != '0));
    assign wlen      = host_autoinc ? HALF_C : st_q.uncov;
    assign rd_ok     = host_rd && (rf_count != '0) && !flush;
    assign wr_ok     = host_wr && (wf_count != DEPTH_C)
                       && (host_autoinc || (st_q.uncov == '0));
    assign rf_push   = mrd_valid && (st_q.rdrop == '0) && !flush;
    assign wpop      = (st_q.wstr != '0);
    assign rlen      = CW'(rsz_words(rsz, DEPTH));

    hp_rd_sizer #(.DEPTH(DEPTH)) u_sizer (
        .rd        (host_rd),
        .autoinc   (host_autoinc),
        .rcount    (rf_count),
        .idle      (st_q.rout == '0),
        .slot_free (slot_free && !wgen),
        .hold      (flush),
        .size      (rsz)
    );

    always_comb begin
        st_d        = st_q;
        st_d.auto_m = host_autoinc;
        if (fire) st_d.mv = 1'b0;

        // write data streaming after accepted write requests
        if (wpop) st_d.wstr = st_q.wstr - 1'b1;
        if (fire && st_q.mw) st_d.wstr = st_d.wstr + st_q.ml;

        // returned read words: discarded ones first
        if (mrd_valid) begin
            if (st_q.rdrop != '0) st_d.rdrop = st_q.rdrop - 1'b1;
            else                  st_d.rout  = st_q.rout - 1'b1;
        end

        // write request generation
        uncov_rem = st_q.uncov - (wgen ? wlen : '0);
        if (wgen) begin
            st_d.mv    = 1'b1;
            st_d.mw    = 1'b1;
            st_d.ma    = st_q.waddr;
            st_d.ml    = wlen;
            st_d.waddr = st_q.waddr + (AW'(wlen) << 2);
        end
        st_d.uncov = uncov_rem + CW'(wr_ok);
        if (wr_ok && uncov_rem == '0) st_d.waddr = st_q.haddr;

        // read request generation
        if (rsz != RSZ_NONE) begin
            st_d.mv   = 1'b1;
            st_d.mw   = 1'b0;
            st_d.ml   = rlen;
            st_d.rout = st_d.rout + rlen;
            if (rsz == RSZ_QUAD) begin
                st_d.ma    = st_q.faddr;
                st_d.faddr = st_q.faddr + (AW'(rlen) << 2);
            end else begin
                st_d.ma    = st_q.haddr;
                st_d.faddr = st_q.haddr + (AW'(rlen) << 2);
            end
        end

        // anything still in flight for the read FIFO becomes stale
        if (flush) begin
            st_d.rdrop = st_d.rdrop + st_d.rout;
            st_d.rout  = '0;
        end

        if (host_autoinc && (rd_ok || wr_ok)) st_d.haddr = st_q.haddr + AW'(4);
        if (haddr_ld) st_d.haddr = haddr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rd_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rf_push),
        .din   (mrd_data),
        .pop   (rd_ok),
        .dout  (rf_dout),
        .count (rf_count)
    );

    hp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_wr_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (1'b0),
        .push  (wr_ok),
        .din   (host_wdata),
        .pop   (wpop),
        .dout  (wf_dout),
        .count (wf_count)
    );

    assign host_rdata = rf_dout;
    assign host_ready = rd_ok || wr_ok;
    assign mreq_valid = st_q.mv;
    assign mreq_write = st_q.mw;
    assign mreq_addr  = st_q.ma;
    assign mreq_len   = st_q.ml;
    assign mwd_valid  = wpop;
    assign mwd_data   = wf_dout;

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)
            && $stable(mreq_len) && $stable(mreq_write))); // R11
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> ((mreq_len != '0) && (mreq_len <= DEPTH_C))); // R4
    AST_RD_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.rout} + {1'b0, rf_count}) <= {1'b0, DEPTH_C}); // R5
    AST_WR_COVERAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.uncov} + {1'b0, st_q.wstr}) <= {1'b0, wf_count}); // R7

endmodule

// File: tb/hp_burst_gen_tb.sv
`timescale 1ns/1ps
module hp_burst_gen_tb;
    localparam int DW = 32;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_autoinc = 1'b0, haddr_ld = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [AW-1:0] haddr_in = '0;
    logic [DW-1:0] host_wdata = '0, host_rdata, mwd_data;
    logic [DW-1:0] mrd_data = '0;
    logic host_ready, mreq_valid, mreq_write, mwd_valid;
    logic mrd_valid = 1'b0;
    logic mrdy = 1'b1;
    logic rd_hold = 1'b0;
    logic [AW-1:0] mreq_addr;
    logic [3:0] mreq_len;

    always #2 clk = ~clk;

    hp_burst_gen #(.DW(DW), .AW(AW), .DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_autoinc(host_autoinc), .haddr_ld(haddr_ld),
        .haddr_in(haddr_in), .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .mreq_valid(mreq_valid),
        .mreq_ready(mrdy), .mreq_write(mreq_write), .mreq_addr(mreq_addr),
        .mreq_len(mreq_len), .mwd_valid(mwd_valid), .mwd_data(mwd_data),
        .mrd_valid(mrd_valid), .mrd_data(mrd_data)
    );

    function automatic logic [DW-1:0] memval(logic [AW-1:0] a);
        return {16'hC0DE, a};
    endfunction

    // monitor: request log, write data log, read address pipe
    logic          lg_w [0:63];
    logic [AW-1:0] lg_a [0:63];
    logic [3:0]    lg_l [0:63];
    logic [DW-1:0] wd_log [0:63];
    logic [AW-1:0] pa [0:255];
    int nreq = 0, nwd = 0, pw = 0, pr = 0, str_left = 0;
    int mon_checks = 0, mon_fails = 0;
    int checks = 0, failures = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (str_left > 0) begin
                mon_checks++;
                if (!mwd_valid) begin
                    mon_fails++;
                    $display("FAIL R12 write data gap act=0 exp=1");
                end
            end
            if (mwd_valid) begin
                if (str_left == 0) begin
                    mon_fails++;
                    $display("FAIL R12 unexpected write beat act=1 exp=0");
                end else str_left--;
                wd_log[nwd % 64] = mwd_data;
                nwd++;
            end
            if (mreq_valid && mrdy) begin
                lg_w[nreq % 64] = mreq_write;
                lg_a[nreq % 64] = mreq_addr;
                lg_l[nreq % 64] = mreq_len;
                nreq++;
                if (mreq_write) str_left += int'(mreq_len);
                else for (int i = 0; i < int'(mreq_len); i++) begin
                    pa[pw % 256] = mreq_addr + AW'(4 * i);
                    pw++;
                end
            end
        end
    end

    // memory read return, one word per cycle, in order
    always @(negedge clk) begin
        if (!rd_hold && pr < pw) begin
            mrd_valid <= 1'b1;
            mrd_data  <= memval(pa[pr % 256]);
            pr <= pr + 1;
        end else begin
            mrd_valid <= 1'b0;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_req(input int idx, input logic w, input logic [AW-1:0] a, input int l, input string tag);
        chk(nreq > idx, {tag, " request present"}, nreq, idx + 1);
        if (nreq > idx) begin
            chk(lg_w[idx % 64] == w, {tag, " direction"}, lg_w[idx % 64], w);
            chk(lg_a[idx % 64] == a, {tag, " address"}, lg_a[idx % 64], a);
            chk(lg_l[idx % 64] == 4'(l), {tag, " length"}, lg_l[idx % 64], l);
        end
    endtask

    task automatic wait_ready();
        int n = 0;
        #1;
        while (!host_ready && n < 300) begin
            @(negedge clk); #1; n++;
        end
        if (!host_ready) chk(1'b0, "host access timeout", 0, 1);
    endtask

    task automatic finish_read(output logic [DW-1:0] d);
        wait_ready();
        d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic host_read(output logic [DW-1:0] d);
        @(negedge clk);
        host_rd = 1'b1;
        finish_read(d);
    endtask

    task automatic finish_write();
        wait_ready();
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_write(input logic [DW-1:0] v);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = v;
        finish_write();
    endtask

    task automatic load_addr(input logic [AW-1:0] a, input logic autom);
        @(negedge clk);
        haddr_ld = 1'b1; haddr_in = a; host_autoinc = autom;
        @(negedge clk);
        haddr_ld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic [AW-1:0] a0, a1;
        int base, wbase;

        repeat (5) @(negedge clk);
        #1;
        chk(!mreq_valid, "R1 no request in reset", mreq_valid, 0);
        rst_n = 1'b1;
        idle(2); #1;
        chk(!mreq_valid, "R1 no request after reset", mreq_valid, 0);
        chk(!mwd_valid, "R1 no write beat after reset", mwd_valid, 0);
        chk(!host_ready, "R1 host_ready low after reset", host_ready, 0);

        // R2 single reads at a fixed address
        load_addr(16'h0100, 1'b0);
        base = nreq;
        host_read(d);
        chk(d == memval(16'h0100), "R2 single read data", d, memval(16'h0100));
        idle(3);
        chk(nreq == base + 1, "R2 one request per single read", nreq, base + 1);
        chk_req(base, 1'b0, 16'h0100, 1, "R2 first single read");
        host_read(d);
        idle(3);
        chk_req(base + 1, 1'b0, 16'h0100, 1, "R2 address held in single mode");
        chk(d == memval(16'h0100), "R2 second single read data", d, memval(16'h0100));

        // R3, R5, R9: eight-word prefetch from empty, stall while empty
        rd_hold = 1'b1;
        load_addr(16'h0200, 1'b1);
        base = nreq;
        @(negedge clk);
        host_rd = 1'b1;
        idle(10); #1;
        chk(!host_ready, "R9 read stalled while FIFO empty", host_ready, 0);
        chk(nreq == base + 1, "R5 no repeat while outstanding", nreq, base + 1);
        chk_req(base, 1'b0, 16'h0200, 8, "R3 empty auto read");
        rd_hold = 1'b0;
        finish_read(d);
        chk(d == memval(16'h0200), "R3 first prefetched word", d, memval(16'h0200));
        idle(12);
        for (int i = 1; i < 4; i++) begin
            host_read(d);
            chk(d == memval(AW'(16'h0200 + 4 * i)), "R8 auto read data order", d, memval(AW'(16'h0200 + 4 * i)));
        end
        idle(3);
        chk(nreq == base + 1, "R5 no request above half full", nreq, base + 1);
        host_read(d);
        chk(d == memval(16'h020C + 16'h4), "R8 fifth word", d, memval(16'h0210));
        idle(3);
        chk_req(base + 1, 1'b0, 16'h0220, 4, "R4 half-full top-up");
        for (int i = 5; i < 13; i++) begin
            host_read(d);
            chk(d == memval(AW'(16'h0200 + 4 * i)), "R3 streamed read data", d, memval(AW'(16'h0200 + 4 * i)));
        end
        idle(12);
        for (int k = base + 1; k < nreq; k++) begin
            a0 = lg_a[(k - 1) % 64] + AW'(4 * int'(lg_l[(k - 1) % 64]));
            chk(lg_a[k % 64] == a0, "R4 contiguous read requests", lg_a[k % 64], a0);
            chk(lg_l[k % 64] == 4'd4 && !lg_w[k % 64], "R4 top-up length", lg_l[k % 64], 4);
        end

        // R10 read side: leaving auto mode drops prefetched data
        @(negedge clk);
        host_autoinc = 1'b0;
        idle(2);
        base = nreq;
        host_read(d);
        idle(3);
        chk_req(base, 1'b0, 16'h0234, 1, "R10 fresh request after mode exit");
        chk(d == memval(16'h0234), "R10 single read data", d, memval(16'h0234));

        // R11 request held until accepted
        mrdy = 1'b0;
        base = nreq;
        @(negedge clk);
        host_rd = 1'b1;
        idle(2); #1;
        a1 = mreq_addr;
        idle(5); #1;
        chk(mreq_valid, "R11 request still presented", mreq_valid, 1);
        chk(mreq_addr == a1 && mreq_addr == 16'h0234, "R11 address stable", mreq_addr, 16'h0234);
        chk(mreq_len == 4'd1 && !mreq_write, "R11 length stable", mreq_len, 1);
        mrdy = 1'b1;
        finish_read(d);
        chk(d == memval(16'h0234), "R11 data after acceptance", d, memval(16'h0234));

        // R6 single writes
        load_addr(16'h0400, 1'b0);
        base = nreq; wbase = nwd;
        host_write(32'h0000_0011);
        idle(4);
        chk_req(base, 1'b1, 16'h0400, 1, "R6 single write");
        host_write(32'h0000_0022);
        idle(4);
        chk_req(base + 1, 1'b1, 16'h0400, 1, "R6 second single write");
        chk(nwd == wbase + 2, "R12 single write beats", nwd, wbase + 2);
        chk(wd_log[wbase % 64] == 32'h11 && wd_log[(wbase + 1) % 64] == 32'h22,
            "R6 single write data", wd_log[(wbase + 1) % 64], 32'h22);

        // R7, R8, R10 auto writes
        load_addr(16'h0500, 1'b1);
        base = nreq; wbase = nwd;
        for (int i = 0; i < 3; i++) host_write(32'hA000_0000 + i);
        idle(4);
        chk(nreq == base, "R7 no request before fourth word", nreq, base);
        host_write(32'hA000_0003);
        idle(4);
        chk_req(base, 1'b1, 16'h0500, 4, "R7 first burst write");
        for (int i = 4; i < 8; i++) host_write(32'hA000_0000 + i);
        idle(4);
        chk_req(base + 1, 1'b1, 16'h0510, 4, "R8 second burst write");
        host_write(32'hA000_0008);
        host_write(32'hA000_0009);
        idle(4);
        chk(nreq == base + 2, "R7 two words held", nreq, base + 2);
        @(negedge clk);
        host_autoinc = 1'b0;
        idle(4);
        chk_req(base + 2, 1'b1, 16'h0520, 2, "R10 leftover write flushed");
        host_write(32'h0000_00EE);
        idle(4);
        chk_req(base + 3, 1'b1, 16'h0528, 1, "R10 single write after flush");
        chk(nwd == wbase + 11, "R12 burst write beats", nwd, wbase + 11);
        for (int i = 0; i < 10; i++)
            chk(wd_log[(wbase + i) % 64] == 32'hA000_0000 + i, "R12 write data order",
                wd_log[(wbase + i) % 64], 32'hA000_0000 + i);
        chk(wd_log[(wbase + 10) % 64] == 32'hEE, "R10 single write data", wd_log[(wbase + 10) % 64], 32'hEE);

        // R9 write stall when the write FIFO is full
        mrdy = 1'b0;
        load_addr(16'h0600, 1'b1);
        base = nreq; wbase = nwd;
        for (int i = 0; i < 8; i++) host_write(32'hB000_0000 + i);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = 32'hB000_0008;
        idle(5); #1;
        chk(!host_ready, "R9 write stalled while FIFO full", host_ready, 0);
        mrdy = 1'b1;
        finish_write();
        idle(20);
        chk_req(base, 1'b1, 16'h0600, 4, "R7 burst after stall");
        chk_req(base + 1, 1'b1, 16'h0610, 4, "R7 second burst after stall");
        chk(nreq == base + 2, "R7 ninth word held", nreq, base + 2);
        @(negedge clk);
        host_autoinc = 1'b0;
        idle(6);
        chk_req(base + 2, 1'b1, 16'h0620, 1, "R10 single leftover word");
        chk(nwd == wbase + 9, "R12 beats after stall", nwd, wbase + 9);
        for (int i = 0; i < 9; i++)
            chk(wd_log[(wbase + i) % 64] == 32'hB000_0000 + i, "R12 stalled write order",
                wd_log[(wbase + i) % 64], 32'hB000_0000 + i);

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fails);
        $finish;
    end
endmodule